// File: doc/BRIEF.md
# Character Console Register Block

This block sits on a simple processor bus and gives software four 16-bit registers for a character console: a status word and a data word for incoming characters, and a status word and a data word for outgoing characters. On the device side it takes 8-bit characters from an input stream and hands 8-bit characters to an output stream. Both streams use valid/ready handshakes. It tracks a "character waiting" flag for input and a "display free" flag for output. It also raises an interrupt request when a character is waiting and software has enabled the interrupt. Scanning a keyboard, framing serial data and drawing glyphs are left to the devices on either side.

Bus reads are combinational from the current register state. Reads and writes take effect at the rising clock edge while `bus_sel` is high.

The input stream never applies back-pressure: `kin_ready` is always high. A character that arrives while the previous one is still unread replaces it.

The output stream follows the usual rules. Once `dout_valid` rises, it stays high with `dout_data` unchanged until a cycle in which `dout_ready` is also high. The sink may hold `dout_ready` low for any number of cycles. A bus write to the output data register is dropped while a character is still pending.

The register offsets are fixed because software decodes them:

| Address | Register |
|---|---|
| 0xFE00 | input status |
| 0xFE02 | input data |
| 0xFE04 | output status |
| 0xFE06 | output data |

Inside the status and data words the bit positions are also fixed:

| Bit(s) | Meaning |
|---|---|
| Input status bit 15 | character waiting |
| Input status bit 14 | interrupt enable |
| Output status bit 15 | display free |
| Data words, bits 7:0 | the character |
| Data words, bits 15:8 | read as zero |

Top module: `char_console_regs`

## Requirements
- R1: After reset the registers read as follows: input status 0x0000, output status 0x8000, output data 0x0000. `kbd_irq` and `dout_valid` are low.
- R2: A cycle with `kin_valid` high captures `kin_data`. From the next cycle, input status bit 15 reads 1 and input data (0xFE02) reads {8'h00, character}.
- R3: A bus read of 0xFE02 clears the waiting flag from the next cycle. If a character arrives in the same cycle, the arrival wins and the flag stays set. Reads of any other address leave the flag unchanged.
- R4: A character that arrives while the waiting flag is set overwrites the held character, and the flag stays 1.
- R5: A bus write to 0xFE00 stores only bit 14 as the interrupt enable. Input status bit 15 cannot be changed by a write, and bits 13:0 always read 0.
- R6: `kbd_irq` is high exactly when the waiting flag and the interrupt enable are both 1.
- R7: While output status bit 15 is 1, a bus write to 0xFE06 makes the following visible from the next cycle:
  - `dout_valid` high;
  - `dout_data` equal to write data bits 7:0;
  - output status reading 0x0000;
  - output data reading {8'h00, byte}.
- R8: While `dout_valid` is high and `dout_ready` is low, `dout_valid` and `dout_data` hold. After a cycle with both high, `dout_valid` is low and output status reads 0x8000.
- R9: A bus write to 0xFE06 while a character is pending has no effect on `dout_data`, on the output data register, or on the output status register.
- R10: Reads of any unmapped address return 0x0000. Writes to 0xFE02, 0xFE04 or unmapped addresses change no register.
- R11: `kin_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| kin_valid | input | 1 | Input character valid |
| kin_ready | output | 1 | Input ready, tied high |
| kin_data | input | 8 | Input character |
| dout_valid | output | 1 | Output character valid |
| dout_ready | input | 1 | Output sink ready |
| dout_data | output | 8 | Output character |
| kbd_irq | output | 1 | Input interrupt request |

## Verification
The assertions assume that the bus and device inputs are known, never X, while reset is released, and that `bus_addr` is only meaningful while `bus_sel` is high. They also assume the sink may stall indefinitely but never sees `dout_data` change under `dout_valid`.

The stimulus drives every input to a defined value each cycle, changing them only on the falling edge. It biases addresses toward the four mapped words and sometimes picks a random unmapped one. It varies `kin_valid` and `dout_ready` with different densities, so that overwrites, long stalls, dropped writes and read-versus-arrival collisions all occur.

// File: rtl/char_console_pkg.sv
package char_console_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e which;
    logic     rd;
    logic     wr;
  } bus_access_t;

endpackage

// File: rtl/char_console_decode.sv
module char_console_decode
  import char_console_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] KSTAT_A = 16'hFE00,
  parameter logic [15:0] KDATA_A = 16'hFE02,
  parameter logic [15:0] DSTAT_A = 16'hFE04,
  parameter logic [15:0] DDATA_A = 16'hFE06
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output bus_access_t       acc
);

  always_comb begin
    acc.rd = sel & ~we;
    acc.wr = sel & we;
    if (!sel)                          acc.which = SEL_NONE;
    else if (addr == KSTAT_A[ADDR_W-1:0]) acc.which = SEL_KSTAT;
    else if (addr == KDATA_A[ADDR_W-1:0]) acc.which = SEL_KDATA;
    else if (addr == DSTAT_A[ADDR_W-1:0]) acc.which = SEL_DSTAT;
    else if (addr == DDATA_A[ADDR_W-1:0]) acc.which = SEL_DDATA;
    else                               acc.which = SEL_NONE;
  end

endmodule

// File: rtl/char_console_kin.sv
module char_console_kin #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              rd_clear,
  input  logic              ie_we,
  input  logic              ie_wdata,
  output logic              waiting,
  output logic              irq_en,
  output logic [CHAR_W-1:0] held
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      held    <= '0;
    end else if (in_valid) begin
      waiting <= 1'b1;
      held    <= in_data;
    end else if (rd_clear) begin
      waiting <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_en <= 1'b0;
    else if (ie_we) irq_en <= ie_wdata;
  end

  assert_arrival_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> waiting);
  assert_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> held == $past(in_data));
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !in_valid) |=> !waiting);
  assert_ie_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_we |=> $stable(irq_en));

endmodule

// File: rtl/char_console_dout.sv
module char_console_dout #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      out_data <= '0;
    end else if (pending) begin
      if (out_ready) pending <= 1'b0;
    end else if (wr_en) begin
      pending  <= 1'b1;
      out_data <= wr_data;
    end
  end

  assign out_valid = pending;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && wr_en) |=> (out_valid && out_data == $past(wr_data)));
  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_en) |=> $stable(out_data));

endmodule

// File: rtl/char_console_regs.sv
module char_console_regs
  import char_console_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 16,
  parameter int          CHAR_W  = 8,
  parameter logic [15:0] KSTAT_A = 16'hFE00,
  parameter logic [15:0] KDATA_A = 16'hFE02,
  parameter logic [15:0] DSTAT_A = 16'hFE04,
  parameter logic [15:0] DDATA_A = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kin_valid,
  output logic              kin_ready,
  input  logic [CHAR_W-1:0] kin_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [CHAR_W-1:0] dout_data,
  output logic              kbd_irq
);

  localparam int FLAG_BIT = DATA_W - 1;
  localparam int IE_BIT   = DATA_W - 2;
  localparam int PAD_W    = DATA_W - CHAR_W;

  bus_access_t       acc;
  logic              k_wait;
  logic              k_ie;
  logic [CHAR_W-1:0] k_held;

  char_console_decode #(
    .ADDR_W(ADDR_W), .KSTAT_A(KSTAT_A), .KDATA_A(KDATA_A),
    .DSTAT_A(DSTAT_A), .DDATA_A(DDATA_A)
  ) u_decode (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .acc(acc)
  );

  char_console_kin #(.CHAR_W(CHAR_W)) u_kin (
    .clk(clk), .rst_n(rst_n),
    .in_valid(kin_valid), .in_data(kin_data),
    .rd_clear(acc.rd && acc.which == SEL_KDATA),
    .ie_we(acc.wr && acc.which == SEL_KSTAT),
    .ie_wdata(bus_wdata[IE_BIT]),
    .waiting(k_wait), .irq_en(k_ie), .held(k_held)
  );

  char_console_dout #(.CHAR_W(CHAR_W)) u_dout (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc.wr && acc.which == SEL_DDATA),
    .wr_data(bus_wdata[CHAR_W-1:0]),
    .out_ready(dout_ready),
    .out_valid(dout_valid), .out_data(dout_data)
  );

  assign kin_ready = 1'b1;
  assign kbd_irq   = k_wait & k_ie;

  always_comb begin
    bus_rdata = '0;
    unique case (acc.which)
      SEL_KSTAT: begin
        bus_rdata[FLAG_BIT] = k_wait;
        bus_rdata[IE_BIT]   = k_ie;
      end
      SEL_KDATA: bus_rdata = {{PAD_W{1'b0}}, k_held};
      SEL_DSTAT: bus_rdata[FLAG_BIT] = ~dout_valid;
      SEL_DDATA: bus_rdata = {{PAD_W{1'b0}}, dout_data};
      default:   bus_rdata = '0;
    endcase
  end

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr && acc.which == SEL_KSTAT && !bus_wdata[IE_BIT]) |=> !kbd_irq);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && acc.which == SEL_NONE) |-> bus_rdata == '0);
  assert_kin_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    kin_ready);

endmodule

// File: tb/char_console_regs_bench.sv
module char_console_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_KS = 16'hFE00;
  localparam logic [15:0] A_KD = 16'hFE02;
  localparam logic [15:0] A_DS = 16'hFE04;
  localparam logic [15:0] A_DD = 16'hFE06;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        kin_valid = 1'b0, kin_ready;
  logic [7:0]  kin_data = '0;
  logic        dout_valid, dout_ready = 1'b0;
  logic [7:0]  dout_data;
  logic        kbd_irq;

  int checks = 0;
  int errors = 0;

  logic       m_kw, m_ie, m_dp;
  logic [7:0] m_kb, m_db;

  char_console_regs u_char_console_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kin_valid(kin_valid), .kin_ready(kin_ready), .kin_data(kin_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .kbd_irq(kbd_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_read(logic [15:0] a);
    if (a == A_KS) return {m_kw, m_ie, 14'h0};
    if (a == A_KD) return {8'h00, m_kb};
    if (a == A_DS) return {~m_dp, 15'h0};
    if (a == A_DD) return {8'h00, m_db};
    return 16'h0000;
  endfunction

  function automatic string read_tag(logic [15:0] a);
    if (a == A_KS) return "R3_R5";
    if (a == A_KD) return "R2_R4";
    if (a == A_DS) return "R7_R9";
    if (a == A_DD) return "R7_R9";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check combinational view, then advance the model at posedge.
  task automatic step(logic s, logic w, logic [15:0] a, logic [15:0] d,
                      logic kv, logic [7:0] kd, logic dr);
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    kin_valid = kv; kin_data = kd; dout_ready = dr;
    #1;
    if (s && !w) chk(read_tag(a), bus_rdata, exp_read(a));
    chk("R6", {15'h0, kbd_irq}, {15'h0, m_kw & m_ie});
    chk("R8", {15'h0, dout_valid}, {15'h0, m_dp});
    if (m_dp) chk("R8", {8'h0, dout_data}, {8'h0, m_db});
    chk("R11", {15'h0, kin_ready}, 16'h0001);
    @(posedge clk);
    if (kv) begin m_kw = 1'b1; m_kb = kd; end
    else if (s && !w && a == A_KD) m_kw = 1'b0;
    if (s && w && a == A_KS) m_ie = d[14];
    if (m_dp) begin if (dr) m_dp = 1'b0; end
    else if (s && w && a == A_DD) begin m_dp = 1'b1; m_db = d[7:0]; end
  endtask

  task automatic rd(logic [15:0] a);
    step(1'b1, 1'b0, a, 16'h0, 1'b0, 8'h0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7141));
    m_kw = 0; m_ie = 0; m_dp = 0; m_kb = 0; m_db = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    bus_sel = 1'b1; bus_we = 1'b0;
    bus_addr = A_KS; #1; chk("R1", bus_rdata, 16'h0000);
    bus_addr = A_DS; #1; chk("R1", bus_rdata, 16'h8000);
    bus_addr = A_DD; #1; chk("R1", bus_rdata, 16'h0000);
    chk("R1", {14'h0, kbd_irq, dout_valid}, 16'h0);
    // R2 arrival, then R4 overwrite
    step(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 8'h41, 1'b0);
    rd(A_KS);
    step(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 8'h42, 1'b0);
    rd(A_KS); rd(A_KS);
    // R5: write all ones, only bit 14 sticks; R6 irq rises
    step(1'b1, 1'b1, A_KS, 16'hFFFF, 1'b0, 8'h0, 1'b0);
    rd(A_KS);
    // R3 read clears; R3 collision: read plus arrival keeps flag
    rd(A_KD); rd(A_KS);
    step(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 8'h43, 1'b0);
    step(1'b1, 1'b0, A_KD, 16'h0, 1'b1, 8'h44, 1'b0);
    rd(A_KS); rd(A_KD);
    // R10: writes to read-only or unmapped addresses
    step(1'b1, 1'b1, A_KD, 16'h1234, 1'b0, 8'h0, 1'b0);
    step(1'b1, 1'b1, A_DS, 16'h0000, 1'b0, 8'h0, 1'b0);
    step(1'b1, 1'b1, 16'h1000, 16'hFFFF, 1'b0, 8'h0, 1'b0);
    rd(A_KS); rd(A_DS); rd(16'hFE08); rd(16'h0000);
    // R7 send, R9 write dropped while pending, R8 stall then release
    step(1'b1, 1'b1, A_DD, 16'hAB5A, 1'b0, 8'h0, 1'b0);
    rd(A_DS); rd(A_DD);
    step(1'b1, 1'b1, A_DD, 16'h0077, 1'b0, 8'h0, 1'b0);
    rd(A_DD);
    repeat (4) step(1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b0);
    step(1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0, 1'b1);
    rd(A_DS);
    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1:    a = A_KS;
        2, 3:    a = A_KD;
        4, 5:    a = A_DS;
        6, 7, 8: a = A_DD;
        default: a = 16'($urandom);
      endcase
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 1) == 1), a,
           16'($urandom), ($urandom_range(0, 4) == 0), 8'($urandom),
           ($urandom_range(0, 5) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule